// File: doc/BRIEF.md
# Prioritized Interrupt Pending Selector

This block decides which local interrupt a hart should take next. It keeps the pending-interrupt vector, which is updated through a masked write, and a claim mask that hands out interrupt sources to their owners. The interrupt-enable vector, the delegation mask, the current privilege level and the global enable bits arrive as inputs from the surrounding control-register logic. From these the block forms a candidate set. Each candidate is gated by the machine-level or the supervisor-level global enable, depending on whether it is delegated. The lowest-numbered candidate that survives is reported as the cause.

When guest virtualization is active, the three guest interrupt bits leave the normal set and move down one bit position. They are considered only when no non-guest interrupt is enabled under the hypervisor-level supervisor enable. A flag shows when the winner came from that hypervisor-level path, so that trap entry can route it there. The hard-interrupt request is raised whenever any pending bit is set. The selection is registered by default (`REG_OUT`).

Top module: `irq_pick_top`

## Requirements
- R1: A bit is a candidate only when its stored pending bit and its `irq_en` bit are both 1.
- R2: Non-delegated candidates survive when `priv` is below 3 (machine), or when `priv` is 3 and `m_gie` is 1. The privilege encoding is 0 user, 1 supervisor, 3 machine.
- R3: Delegated candidates survive when `priv` is 0, or when `priv` is 1 and `s_gie` is 1.
- R4: A candidate whose `deleg` bit is 1 is gated only by the supervisor rule of R3. A candidate whose `deleg` bit is 0 is gated only by the machine rule of R2.
- R5: Among the surviving bits, the lowest index is reported on `sel_cause` with `sel_valid` high.
- R6: Bits 2, 6 and 10 are guest software, timer and external interrupts. They are never candidates while `virt_on` is 0. While `virt_on` is 1, the non-guest candidates are first gated by the hypervisor rule (`priv` 0, or `priv` 1 with `hs_gie`). If any of them survive, the lowest one wins and `sel_hs` is 1. Otherwise the guest candidates, shifted to bits 1, 5 and 9, go through R2 to R4 with `sel_hs` 0.
- R7: A `claim_req` whose bits overlap `claim_mask` sets `claim_fail` and leaves the mask unchanged. Otherwise the bits are ORed into the mask and `claim_fail` is cleared. `claim_fail` holds until the next request.
- R8: A `pend_wr` replaces only the pending bits selected by `pend_mask` with `pend_val` and shows the prior vector on `pend_old`. `hard_req` is 1 exactly when the stored pending vector is nonzero.
- R9: When nothing survives, `sel_valid` is 0 and `sel_cause` is 0. After reset, the pending vector, the claim mask and all outputs are 0.
- R10: With `REG_OUT` set, `sel_*` reflect the inputs and the stored pending vector as they were one clock edge earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pend_wr | input | 1 | Masked write of the pending vector |
| pend_mask | input | W | Bits to replace on a pending write |
| pend_val | input | W | New values for the selected pending bits |
| pend_old | output | W | Pending vector before the latest write |
| hard_req | output | 1 | Any pending bit set |
| claim_req | input | 1 | Claim request strobe |
| claim_bits | input | W | Sources being claimed |
| claim_mask | output | W | Sources claimed so far |
| claim_fail | output | 1 | Last claim overlapped an existing claim |
| irq_en | input | W | Per-interrupt enables |
| deleg | input | W | Per-interrupt delegation to supervisor |
| priv | input | 2 | Current privilege (0 U, 1 S, 3 M) |
| m_gie | input | 1 | Machine global interrupt enable |
| s_gie | input | 1 | Supervisor global interrupt enable |
| hs_gie | input | 1 | Hypervisor-level supervisor global enable |
| virt_on | input | 1 | Guest virtualization active |
| sel_valid | output | 1 | An interrupt is selected |
| sel_cause | output | CW | Index of the selected interrupt |
| sel_hs | output | 1 | Selection came from the hypervisor-level path |

## Verification
A pending write lands in the stored vector on the first clock edge. `pend_old`, `hard_req`, `claim_mask` and `claim_fail` are due after that same edge. The registered selection follows one edge later, so every stimulus has its results due two rising edges after it is driven. The driver applies each stimulus on a falling edge and queues the expected values. The monitor waits exactly two rising edges and compares at the next falling edge. The driver does not send a new stimulus until the queue is empty, so no result is compared against the wrong stimulus.

// File: rtl/irq_pick_pkg.sv
package irq_pick_pkg;
    localparam logic [1:0] PRIV_U = 2'd0;
    localparam logic [1:0] PRIV_S = 2'd1;
    localparam logic [1:0] PRIV_M = 2'd3;

    // guest interrupt positions; each sits one above its host counterpart
    localparam int GUEST_SW_BIT  = 2;
    localparam int GUEST_TMR_BIT = 6;
    localparam int GUEST_EXT_BIT = 10;
endpackage

// File: rtl/irq_lsb_pick.sv
module irq_lsb_pick #(
    parameter int W  = 32,
    parameter int CW = $clog2(W)
) (
    input  logic [W-1:0]  vec,
    output logic          found,
    output logic [CW-1:0] idx
);
    always_comb begin
        idx = '0;
        for (int i = W - 1; i >= 0; i--) begin
            if (vec[i]) idx = CW'(i);
        end
        found = |vec;
    end
endmodule

// File: rtl/irq_gate.sv
module irq_gate
    import irq_pick_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0] pend,
    input  logic [W-1:0] en,
    input  logic [W-1:0] deleg,
    input  logic [1:0]   priv,
    input  logic         m_gie,
    input  logic         s_gie,
    input  logic         hs_gie,
    input  logic         virt_on,
    output logic [W-1:0] set_out,
    output logic         from_hs
);
    localparam logic [W-1:0] GMASK = (W'(1) << GUEST_SW_BIT) |
                                     (W'(1) << GUEST_TMR_BIT) |
                                     (W'(1) << GUEST_EXT_BIT);

    logic [W-1:0] cand, host_c, guest_c, hs_hits, base;
    logic         m_on, s_on, hs_on;

    always_comb begin
        cand    = pend & en;
        host_c  = cand & ~GMASK;
        guest_c = (cand & GMASK) >> 1;
        m_on    = (priv < PRIV_M) || ((priv == PRIV_M) && m_gie);
        s_on    = (priv < PRIV_S) || ((priv == PRIV_S) && s_gie);
        hs_on   = (priv < PRIV_S) || ((priv == PRIV_S) && hs_gie);
        hs_hits = host_c & {W{hs_on}};
        base    = virt_on ? guest_c : host_c;
        if (virt_on && (|hs_hits)) begin
            set_out = hs_hits;
            from_hs = 1'b1;
        end else begin
            set_out = (base & ~deleg & {W{m_on}}) | (base & deleg & {W{s_on}});
            from_hs = 1'b0;
        end
    end
endmodule

// File: rtl/irq_pick_top.sv
module irq_pick_top
    import irq_pick_pkg::*;
#(
    parameter int W       = 32,
    parameter int CW      = $clog2(W),
    parameter bit REG_OUT = 1'b1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pend_wr,
    input  logic [W-1:0]  pend_mask,
    input  logic [W-1:0]  pend_val,
    output logic [W-1:0]  pend_old,
    output logic          hard_req,
    input  logic          claim_req,
    input  logic [W-1:0]  claim_bits,
    output logic [W-1:0]  claim_mask,
    output logic          claim_fail,
    input  logic [W-1:0]  irq_en,
    input  logic [W-1:0]  deleg,
    input  logic [1:0]    priv,
    input  logic          m_gie,
    input  logic          s_gie,
    input  logic          hs_gie,
    input  logic          virt_on,
    output logic          sel_valid,
    output logic [CW-1:0] sel_cause,
    output logic          sel_hs
);
    typedef struct packed {
        logic [W-1:0]  pend;
        logic [W-1:0]  old;
        logic [W-1:0]  claim;
        logic          cfail;
        logic          vld;
        logic [CW-1:0] cause;
        logic          hs;
    } state_t;

    state_t        st_d, st_q;
    logic [W-1:0]  set_w;
    logic          hs_w;
    logic          pick_found;
    logic [CW-1:0] pick_idx;

    irq_gate #(.W(W)) i_gate (
        .pend    (st_q.pend),
        .en      (irq_en),
        .deleg   (deleg),
        .priv    (priv),
        .m_gie   (m_gie),
        .s_gie   (s_gie),
        .hs_gie  (hs_gie),
        .virt_on (virt_on),
        .set_out (set_w),
        .from_hs (hs_w)
    );

    irq_lsb_pick #(.W(W), .CW(CW)) i_pick (
        .vec   (set_w),
        .found (pick_found),
        .idx   (pick_idx)
    );

    always_comb begin
        st_d = st_q;
        if (pend_wr) begin
            st_d.pend = (st_q.pend & ~pend_mask) | (pend_val & pend_mask);
            st_d.old  = st_q.pend;
        end
        if (claim_req) begin
            if (|(st_q.claim & claim_bits)) begin
                st_d.cfail = 1'b1;
            end else begin
                st_d.claim = st_q.claim | claim_bits;
                st_d.cfail = 1'b0;
            end
        end
        st_d.vld   = pick_found;
        st_d.cause = pick_found ? pick_idx : '0;
        st_d.hs    = pick_found && hs_w;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pend_old   = st_q.old;
    assign hard_req   = |st_q.pend;
    assign claim_mask = st_q.claim;
    assign claim_fail = st_q.cfail;

    generate
        if (REG_OUT) begin : g_reg
            assign sel_valid = st_q.vld;
            assign sel_cause = st_q.cause;
            assign sel_hs    = st_q.hs;
        end else begin : g_comb
            assign sel_valid = st_d.vld;
            assign sel_cause = st_d.cause;
            assign sel_hs    = st_d.hs;
        end
    endgenerate

    AST_PICK_IN_SET: assert property (@(posedge clk) disable iff (!rst_n)
        pick_found |-> set_w[pick_idx]) else $error("pick not in set"); // R5
    AST_PICK_LOWEST: assert property (@(posedge clk) disable iff (!rst_n)
        pick_found |-> ((set_w & ((W'(1) << pick_idx) - W'(1))) == '0)) else $error("pick not lowest"); // R5
    AST_NONE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !sel_valid |-> (sel_cause == '0)) else $error("cause nonzero"); // R9
    AST_HS_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        sel_hs |-> sel_valid) else $error("hs without valid"); // R6
    AST_CLAIM_REFUSE: assert property (@(posedge clk) disable iff (!rst_n)
        (claim_req && (|(claim_mask & claim_bits))) |=> (claim_fail && $stable(claim_mask)))
        else $error("claim refuse"); // R7
    AST_CLAIM_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        (claim_req && !(|(claim_mask & claim_bits))) |=>
        (!claim_fail && (claim_mask == ($past(claim_mask) | $past(claim_bits)))))
        else $error("claim grant"); // R7
    AST_PEND_OLD: assert property (@(posedge clk) disable iff (!rst_n)
        pend_wr |=> (pend_old == $past(st_q.pend))) else $error("old value"); // R8
endmodule

// File: tb/test_irq_pick_top.sv
module test_irq_pick_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pend_wr = 1'b0;
    logic [31:0] pend_mask = '0, pend_val = '0, pend_old;
    logic        hard_req;
    logic        claim_req = 1'b0;
    logic [31:0] claim_bits = '0, claim_mask;
    logic        claim_fail;
    logic [31:0] irq_en = '0, deleg = '0;
    logic [1:0]  priv = 2'd3;
    logic        m_gie = 1'b0, s_gie = 1'b0, hs_gie = 1'b0, virt_on = 1'b0;
    logic        sel_valid, sel_hs;
    logic [4:0]  sel_cause;

    int n_tests = 0;
    int n_fail  = 0;

    typedef struct {
        string       req;
        logic [31:0] old;
        logic        hard;
        logic        vld;
        logic [4:0]  cause;
        logic        hs;
        logic [31:0] cmask;
        logic        cfail;
    } item_t;

    item_t q[$];

    logic [31:0] m_pend = '0, m_old = '0, m_claim = '0;
    logic        m_cfail = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    irq_pick_top i_irq_pick_top (
        .clk(clk), .rst_n(rst_n),
        .pend_wr(pend_wr), .pend_mask(pend_mask), .pend_val(pend_val),
        .pend_old(pend_old), .hard_req(hard_req),
        .claim_req(claim_req), .claim_bits(claim_bits),
        .claim_mask(claim_mask), .claim_fail(claim_fail),
        .irq_en(irq_en), .deleg(deleg), .priv(priv),
        .m_gie(m_gie), .s_gie(s_gie), .hs_gie(hs_gie), .virt_on(virt_on),
        .sel_valid(sel_valid), .sel_cause(sel_cause), .sel_hs(sel_hs)
    );

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // reference selection written from the requirements
    task automatic ref_sel(output logic vld, output logic [4:0] cause, output logic hs);
        logic [31:0] c, host, guest, surv, hsv;
        logic mok, sok, hok;
        c = m_pend & irq_en;
        host = c;
        guest = '0;
        host[2] = 1'b0; host[6] = 1'b0; host[10] = 1'b0;
        guest[1] = c[2]; guest[5] = c[6]; guest[9] = c[10];
        mok = (priv != 2'd3) || m_gie;
        sok = (priv == 2'd0) || ((priv == 2'd1) && s_gie);
        hok = (priv == 2'd0) || ((priv == 2'd1) && hs_gie);
        hsv = hok ? host : '0;
        hs = 1'b0;
        if (virt_on && (hsv != 0)) begin
            surv = hsv;
            hs = 1'b1;
        end else begin
            surv = '0;
            for (int i = 0; i < 32; i++) begin
                if ((virt_on ? guest[i] : host[i]) && (deleg[i] ? sok : mok)) surv[i] = 1'b1;
            end
        end
        vld = 1'b0;
        cause = '0;
        for (int i = 31; i >= 0; i--) begin
            if (surv[i]) begin vld = 1'b1; cause = 5'(i); end
        end
    endtask

    task automatic push_expect(string req);
        item_t it;
        logic v, h;
        logic [4:0] c;
        ref_sel(v, c, h);
        it.req = req; it.old = m_old; it.hard = (m_pend != 0);
        it.vld = v; it.cause = c; it.hs = h;
        it.cmask = m_claim; it.cfail = m_cfail;
        q.push_back(it);
        @(negedge clk);
        pend_wr = 1'b0;
        claim_req = 1'b0;
        wait (q.size() == 0);
        @(negedge clk);
    endtask

    task automatic run_sel(string req, logic [31:0] wm, logic [31:0] wv, logic [31:0] en,
                           logic [31:0] dg, logic [1:0] pr, logic m, logic s, logic h, logic v);
        pend_wr = 1'b1; pend_mask = wm; pend_val = wv;
        irq_en = en; deleg = dg; priv = pr;
        m_gie = m; s_gie = s; hs_gie = h; virt_on = v;
        m_old  = m_pend;
        m_pend = (m_pend & ~wm) | (wv & wm);
        push_expect(req);
    endtask

    task automatic run_claim(string req, logic [31:0] bits);
        claim_req = 1'b1; claim_bits = bits;
        if ((m_claim & bits) != 0) m_cfail = 1'b1;
        else begin m_claim = m_claim | bits; m_cfail = 1'b0; end
        push_expect(req);
    endtask

    // monitor: results are due two rising edges after the stimulus
    initial begin
        item_t it;
        forever begin
            wait (q.size() > 0);
            repeat (2) @(posedge clk);
            @(negedge clk);
            it = q[0];
            chk(it.req, "pend_old", pend_old, it.old);
            chk(it.req, "hard_req", 32'(hard_req), 32'(it.hard));
            chk(it.req, "sel_valid", 32'(sel_valid), 32'(it.vld));
            chk(it.req, "sel_cause", 32'(sel_cause), 32'(it.cause));
            chk(it.req, "sel_hs", 32'(sel_hs), 32'(it.hs));
            chk(it.req, "claim_mask", claim_mask, it.cmask);
            chk(it.req, "claim_fail", 32'(claim_fail), 32'(it.cfail));
            void'(q.pop_front());
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R9 reset state
        chk("R9", "reset sel_valid", 32'(sel_valid), 0);
        chk("R9", "reset sel_cause", 32'(sel_cause), 0);
        chk("R9", "reset hard_req", 32'(hard_req), 0);
        chk("R9", "reset claim_mask", claim_mask, 0);

        // machine mode, enabled: lowest of 3 and 7
        run_sel("R1/R2/R5", '1, 32'h0000_0088, '1, '0, 2'd3, 1'b1, 1'b0, 1'b0, 1'b0);
        // machine mode, m_gie off: nothing
        run_sel("R2/R9", '0, '0, '1, '0, 2'd3, 1'b0, 1'b0, 1'b0, 1'b0);
        // user mode: machine gate always open
        run_sel("R2", '0, '0, '1, '0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0);
        // enable off for bit 3 -> bit 7
        run_sel("R1", '0, '0, 32'hFFFF_FFF7, '0, 2'd3, 1'b1, 1'b0, 1'b0, 1'b0);
        // delegated bit 1 in S mode with s_gie off; non-delegated bit 5 wins
        run_sel("R3/R4", '1, 32'h0000_0022, '1, 32'h0000_0002, 2'd1, 1'b0, 1'b0, 1'b0, 1'b0);
        // S mode s_gie on -> bit 1
        run_sel("R3", '0, '0, '1, 32'h0000_0002, 2'd1, 1'b0, 1'b1, 1'b0, 1'b0);
        // M mode: delegated-only pending is masked
        run_sel("R4", '1, 32'h0000_0002, '1, 32'h0000_0002, 2'd3, 1'b1, 1'b1, 1'b0, 1'b0);
        // masked write touches bit 9 only; bit 1 kept
        run_sel("R8", 32'h0000_0200, 32'hFFFF_FFFF, '1, '0, 2'd3, 1'b1, 1'b0, 1'b0, 1'b0);
        // clear all: hard request drops
        run_sel("R8/R9", '1, '0, '1, '0, 2'd3, 1'b1, 1'b0, 1'b0, 1'b0);
        // guest bit ignored without virtualization
        run_sel("R6", '1, 32'h0000_0004, '1, '0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0);
        // guest timer shifts to 5 under virtualization
        run_sel("R6", '1, 32'h0000_0040, '1, '0, 2'd1, 1'b0, 1'b0, 1'b1, 1'b1);
        // host bit 11 taken at hypervisor level first
        run_sel("R6", '1, 32'h0000_0840, '1, '0, 2'd1, 1'b0, 1'b0, 1'b1, 1'b1);
        // hs gate closed: guest software shifts to 1
        run_sel("R6", '1, 32'h0000_0804, '1, '0, 2'd1, 1'b0, 1'b0, 1'b0, 1'b1);
        // registered selection follows a configuration change one edge later
        run_sel("R10", '0, '0, '1, '0, 2'd3, 1'b0, 1'b0, 1'b0, 1'b0);
        // claims
        run_claim("R7", 32'h0000_0003);
        run_claim("R7", 32'h0000_0006);
        run_claim("R7", 32'h0000_0010);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule